// File: doc/BRIEF.md
# Palette DAC Port with Clock Synthesizer Registers

This block is the host-facing byte port of a palette DAC that also contains a programmable clock synthesizer. The host reaches it through four byte addresses: the pixel mask, a write index, a read index and a data port. A mode input decides where the index and data ports lead. When the input is low they address a small palette store. When it is high they address a bank of synthesizer slots, and each slot is a pair of bytes: the multiplier M first, then the divider byte N.

Slots 0 and 1 hold two fixed reference clocks. Slot 2 is the programmable pixel clock, slot 0x0A is the memory clock, and index 0x0E holds a single control byte. The decoded clock fields, the control byte, the pixel mask and the command byte are presented as outputs for the clock generator and the pixel pipeline.

A hidden command register sits behind the pixel-mask address. The host writes the write index and then reads the mask address a set number of times in a row. The last read of that run returns an identification byte. From then on, accesses to the mask address go to the command register.

Top module: `dac_pll_port`

## Requirements
- R1: After a synchronous reset, bus_rdata is 0x00, pix_mask is 0xFF, and dac_cmd, pll_ctrl and all clock fields are zero.
- R2: With pll_mode low, a data-port write stores the byte in the palette entry selected by the low PAL_AW bits of the write index. A data-port read returns the entry selected by the read index. Each such access advances its index by one.
- R3: With pll_mode high, successive data-port accesses on one index visit byte M and then byte N, and after N the index moves to the next slot. The read index and the write index each keep their own byte phase. Writing an index port sets that index and returns its phase to M.
- R4: Slot 0 reads M=0x28, N=0x61 and slot 1 reads M=0x3D, N=0x62. Writes to either slot change nothing.
- R5: Slots 2 and 0x0A keep bits [6:0] of each written byte and read back with bit 7 clear. Their N byte drives the N1 output from bits [4:0] and the N2 output from bits [6:5].
- R6: Index 0x0E holds one full control byte on pll_ctrl, and a single data access moves the index on to 0x0F.
- R7: Every other slot reads 0x00, and writes to it are ignored.
- R8: The port opens after a write-index write followed by SEQ_LEN consecutive mask reads (4 by default). Reads before the last return pix_mask. The last returns CHIP_ID (0x71 by default, upper nibble 0x7). After that, mask reads return dac_cmd and mask writes load dac_cmd while pix_mask stays unchanged.
- R9: An access to any other port, or a mask write made before the port opens, cancels the count and closes the command register. A new write-index write starts the count again from zero.
- R10: Reading the write-index port returns the write index. Reading the read-index port returns the read index.
- R11: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Port select: 0 mask, 1 write index, 2 read index, 3 data |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pll_mode | input | 1 | High: index/data ports reach the synthesizer bank |
| pix_m | output | 7 | Pixel clock multiplier |
| pix_n1 | output | 5 | Pixel clock pre-divider |
| pix_n2 | output | 2 | Pixel clock post-divider exponent |
| mem_m | output | 7 | Memory clock multiplier |
| mem_n1 | output | 5 | Memory clock pre-divider |
| mem_n2 | output | 2 | Memory clock post-divider exponent |
| pll_ctrl | output | 8 | Synthesizer control byte |
| dac_cmd | output | 8 | Hidden command register |
| pix_mask | output | 8 | Pixel mask |

## Verification
The hardest situation to reach is the hidden command register. It opens only after an exact run of mask reads that follows an index write, so the bench also builds near-misses: the run broken by a data read, by a mask write, and restarted by a second index write. Each near-miss must still return the mask and never the identification byte. The synthesizer bank is swept over every byte of slots 0 to 15, once for reads and once for writes. This sweep carries the pointers across the single-byte control slot, where the M/N pairing shifts, and the bench model predicts every byte arithmetically.

// File: rtl/dac_pll_pkg.sv
package dac_pll_pkg;
  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_WIDX = 2'd1,
    PORT_RIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  localparam logic [7:0] SLOT_FIX0 = 8'h00;
  localparam logic [7:0] SLOT_FIX1 = 8'h01;
  localparam logic [7:0] SLOT_PIX  = 8'h02;
  localparam logic [7:0] SLOT_MEM  = 8'h0A;
  localparam logic [7:0] SLOT_CTRL = 8'h0E;

  localparam logic [7:0] FIX0_M = 8'h28;
  localparam logic [7:0] FIX0_N = 8'h61;
  localparam logic [7:0] FIX1_M = 8'h3D;
  localparam logic [7:0] FIX1_N = 8'h62;

  typedef struct packed {
    logic [6:0] m;
    logic [6:0] n;
  } pll_pair_t;
endpackage

// File: rtl/dac_idx_ptr.sv
module dac_idx_ptr #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [IW-1:0] load_val,
  input  logic          step,
  input  logic          pll_mode,
  input  logic          single,
  output logic [IW-1:0] idx,
  output logic          phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= 1'b0;
    end else if (load) begin
      idx   <= load_val;
      phase <= 1'b0;
    end else if (step) begin
      if (!pll_mode || single || phase) begin
        idx   <= idx + 1'b1;
        phase <= 1'b0;
      end else begin
        phase <= 1'b1;
      end
    end
  end

  // R3: index write restarts at byte M
  p_load_phase_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == 1'b0) && (idx == $past(load_val)));

  // R3: second byte of a pair moves to the next slot
  p_pair_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load && pll_mode && phase) |=> (phase == 1'b0) && (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/dac_pll_bank.sv
module dac_pll_bank
  import dac_pll_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic [7:0] widx,
  input  logic      wph,
  input  logic [7:0] wdata,
  input  logic [7:0] ridx,
  input  logic      rph,
  output logic [7:0] rdata,
  output pll_pair_t pix,
  output pll_pair_t mem,
  output logic [7:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix  <= '0;
      mem  <= '0;
      ctrl <= '0;
    end else if (we) begin
      case (widx)
        SLOT_PIX: begin
          if (wph) pix.n <= wdata[6:0];
          else     pix.m <= wdata[6:0];
        end
        SLOT_MEM: begin
          if (wph) mem.n <= wdata[6:0];
          else     mem.m <= wdata[6:0];
        end
        SLOT_CTRL: ctrl <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (ridx)
      SLOT_FIX0: rdata = rph ? FIX0_N : FIX0_M;
      SLOT_FIX1: rdata = rph ? FIX1_N : FIX1_M;
      SLOT_PIX:  rdata = {1'b0, rph ? pix.n : pix.m};
      SLOT_MEM:  rdata = {1'b0, rph ? mem.n : mem.m};
      SLOT_CTRL: rdata = ctrl;
      default:   rdata = 8'h00;
    endcase
  end

  // R4 / R7: writes outside the stored slots leave every register alone
  p_ignored_write_r4: assert property (@(posedge clk) disable iff (rst)
    (we && widx != SLOT_PIX && widx != SLOT_MEM && widx != SLOT_CTRL)
      |=> $stable(pix) && $stable(mem) && $stable(ctrl));
endmodule

// File: rtl/dac_mask_seq.sv
module dac_mask_seq #(
  parameter int         SEQ_LEN  = 4,
  parameter logic [7:0] CHIP_ID  = 8'h71,
  parameter logic [7:0] MASK_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mask_rd,
  input  logic       mask_wr,
  input  logic       arm,
  input  logic       other,
  input  logic [7:0] wdata,
  output logic [7:0] rd_val,
  output logic [7:0] mask,
  output logic [7:0] cmd
);
  localparam int CW = $clog2(SEQ_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  logic          armed;
  logic          open;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      open  <= 1'b0;
      cnt   <= '0;
      mask  <= MASK_RST;
      cmd   <= 8'h00;
    end else if (arm) begin
      armed <= 1'b1;
      open  <= 1'b0;
      cnt   <= '0;
    end else if (other) begin
      armed <= 1'b0;
      open  <= 1'b0;
      cnt   <= '0;
    end else if (mask_rd) begin
      if (armed) begin
        if (cnt == LAST) begin
          open  <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (mask_wr) begin
      if (open) begin
        cmd <= wdata;
      end else begin
        mask  <= wdata;
        armed <= 1'b0;
        cnt   <= '0;
      end
    end
  end

  always_comb begin
    if (open)                       rd_val = cmd;
    else if (armed && cnt == LAST)  rd_val = CHIP_ID;
    else                            rd_val = mask;
  end

  // R8: the last read of the run opens the command register
  p_open_after_run_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_rd && armed && cnt == LAST && !arm && !other) |=> open);

  // R8: while open, mask writes leave the pixel mask alone
  p_mask_kept_open_r8: assert property (@(posedge clk) disable iff (rst)
    (open && mask_wr && !arm && !other) |=> $stable(mask));

  // R9: a foreign access closes and disarms
  p_other_closes_r9: assert property (@(posedge clk) disable iff (rst)
    (other && !arm) |=> !open && !armed);
endmodule

// File: rtl/dac_pal_stub.sv
module dac_pal_stub #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    if (re) q <= mem_q[raddr];
  end
endmodule

// File: rtl/dac_pll_port.sv
module dac_pll_port
  import dac_pll_pkg::*;
#(
  parameter int         PAL_AW   = 4,
  parameter int         SEQ_LEN  = 4,
  parameter logic [7:0] CHIP_ID  = 8'h71,
  parameter logic [7:0] MASK_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       pll_mode,
  output logic [6:0] pix_m,
  output logic [4:0] pix_n1,
  output logic [1:0] pix_n2,
  output logic [6:0] mem_m,
  output logic [4:0] mem_n1,
  output logic [1:0] mem_n2,
  output logic [7:0] pll_ctrl,
  output logic [7:0] dac_cmd,
  output logic [7:0] pix_mask
);
  logic wr_mask, wr_widx, wr_ridx, wr_data;
  logic rd_mask, rd_data, other_acc;

  assign wr_mask   = bus_wr && (bus_addr == PORT_MASK);
  assign wr_widx   = bus_wr && (bus_addr == PORT_WIDX);
  assign wr_ridx   = bus_wr && (bus_addr == PORT_RIDX);
  assign wr_data   = bus_wr && (bus_addr == PORT_DATA);
  assign rd_mask   = bus_rd && (bus_addr == PORT_MASK);
  assign rd_data   = bus_rd && (bus_addr == PORT_DATA);
  assign other_acc = (bus_wr || bus_rd) && (bus_addr != PORT_MASK);

  logic [7:0] widx, ridx;
  logic       wph, rph;

  dac_idx_ptr #(.IW(8)) wptr_i (
    .clk(clk), .rst(rst), .load(wr_widx), .load_val(bus_wdata),
    .step(wr_data), .pll_mode(pll_mode), .single(widx == SLOT_CTRL),
    .idx(widx), .phase(wph)
  );

  dac_idx_ptr #(.IW(8)) rptr_i (
    .clk(clk), .rst(rst), .load(wr_ridx), .load_val(bus_wdata),
    .step(rd_data), .pll_mode(pll_mode), .single(ridx == SLOT_CTRL),
    .idx(ridx), .phase(rph)
  );

  logic [7:0] bank_rd;
  pll_pair_t  pix, mem;

  dac_pll_bank bank_i (
    .clk(clk), .rst(rst), .we(wr_data && pll_mode),
    .widx(widx), .wph(wph), .wdata(bus_wdata),
    .ridx(ridx), .rph(rph), .rdata(bank_rd),
    .pix(pix), .mem(mem), .ctrl(pll_ctrl)
  );

  logic [7:0] seq_rd;

  dac_mask_seq #(.SEQ_LEN(SEQ_LEN), .CHIP_ID(CHIP_ID), .MASK_RST(MASK_RST)) seq_i (
    .clk(clk), .rst(rst), .mask_rd(rd_mask), .mask_wr(wr_mask),
    .arm(wr_widx), .other(other_acc), .wdata(bus_wdata),
    .rd_val(seq_rd), .mask(pix_mask), .cmd(dac_cmd)
  );

  logic [7:0] pal_q;

  dac_pal_stub #(.AW(PAL_AW)) pal_i (
    .clk(clk), .we(wr_data && !pll_mode), .waddr(widx[PAL_AW-1:0]),
    .wdata(bus_wdata), .re(rd_data && !pll_mode), .raddr(ridx[PAL_AW-1:0]),
    .q(pal_q)
  );

  logic [7:0] rdata_r;
  logic       src_pal;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_r <= 8'h00;
      src_pal <= 1'b0;
    end else if (bus_rd) begin
      src_pal <= (bus_addr == PORT_DATA) && !pll_mode;
      case (bus_addr)
        PORT_MASK: rdata_r <= seq_rd;
        PORT_WIDX: rdata_r <= widx;
        PORT_RIDX: rdata_r <= ridx;
        default:   rdata_r <= bank_rd;
      endcase
    end
  end

  assign bus_rdata = src_pal ? pal_q : rdata_r;

  assign pix_m  = pix.m;
  assign pix_n1 = pix.n[4:0];
  assign pix_n2 = pix.n[6:5];
  assign mem_m  = mem.m;
  assign mem_n1 = mem.n[4:0];
  assign mem_n2 = mem.n[6:5];

  // R11: read data holds between read strobes
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R4: first fixed slot returns its M byte
  p_fixed_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && pll_mode && ridx == SLOT_FIX0 && !rph) |=> bus_rdata == FIX0_M);

  // R5: clock bytes read back with bit 7 clear
  p_msb_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_data && pll_mode && ridx != SLOT_CTRL) |=> !bus_rdata[7]);

  // R11: one strobe per cycle
  p_single_strobe_r11: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
endmodule

// File: tb/dac_pll_port_tb.sv
module dac_pll_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pll_mode = 1'b0;
  logic [6:0] pix_m, mem_m;
  logic [4:0] pix_n1, mem_n1;
  logic [1:0] pix_n2, mem_n2;
  logic [7:0] pll_ctrl, dac_cmd, pix_mask;

  always #5 clk = ~clk;

  dac_pll_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_mode(pll_mode),
    .pix_m(pix_m), .pix_n1(pix_n1), .pix_n2(pix_n2),
    .mem_m(mem_m), .mem_n1(mem_n1), .mem_n2(mem_n2),
    .pll_ctrl(pll_ctrl), .dac_cmd(dac_cmd), .pix_mask(pix_mask)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [6:0] e_pm = 0, e_pn = 0, e_mm = 0, e_mn = 0;
  logic [7:0] e_ctrl = 0;
  logic [7:0] pal_exp [16];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); v = bus_rdata; bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] pll_exp(input logic [7:0] s, input logic ph);
    case (s)
      8'h00: return ph ? 8'h61 : 8'h28;
      8'h01: return ph ? 8'h62 : 8'h3D;
      8'h02: return {1'b0, ph ? e_pn : e_pm};
      8'h0A: return {1'b0, ph ? e_mn : e_mm};
      8'h0E: return e_ctrl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic pll_read_sweep(input string tag);
    logic [7:0] s = 0;
    logic ph = 0;
    logic [7:0] v;
    do_wr(2, 8'h00);
    while (s < 8'h10) begin
      do_rd(3, v);
      chk(tag, v, pll_exp(s, ph));
      if (s == 8'h0E || ph) begin s++; ph = 0; end else ph = 1;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 mask", pix_mask, 8'hFF);
    chk("R1 cmd", dac_cmd, 8'h00);
    chk("R1 ctrl", pll_ctrl, 8'h00);
    chk("R1 pix_m", {1'b0, pix_m}, 8'h00);

    // R10 index read-back
    do_wr(1, 8'h05); do_rd(1, v); chk("R10 widx", v, 8'h05);
    do_wr(2, 8'h09); do_rd(2, v); chk("R10 ridx", v, 8'h09);

    // R2 palette sweep
    do_wr(1, 8'h00);
    for (int i = 0; i < 16; i++) begin
      pal_exp[i] = 8'(i * 13 + 7);
      do_wr(3, pal_exp[i]);
    end
    do_wr(2, 8'h00);
    for (int i = 0; i < 17; i++) begin
      do_rd(3, v); chk("R2 palette", v, pal_exp[i % 16]);
    end
    do_rd(2, v); chk("R2 index advance", v, 8'h11);

    // R4 R7 read sweep of reset bank
    pll_mode = 1'b1;
    pll_read_sweep("R4 R7 reset sweep");

    // R3 R4 R5 R6 R7 write sweep
    begin
      logic [7:0] s = 0;
      logic ph = 0;
      do_wr(1, 8'h00);
      for (int k = 0; k < 31; k++) begin
        logic [7:0] d = 8'h80 | 8'(k * 7);
        do_wr(3, d);
        if (s == 8'h02) begin if (ph) e_pn = d[6:0]; else e_pm = d[6:0]; end
        if (s == 8'h0A) begin if (ph) e_mn = d[6:0]; else e_mm = d[6:0]; end
        if (s == 8'h0E) e_ctrl = d;
        if (s == 8'h0E || ph) begin s++; ph = 0; end else ph = 1;
      end
    end
    chk("R5 pix_m", {1'b0, pix_m}, {1'b0, e_pm});
    chk("R5 pix_n1", {3'b0, pix_n1}, {3'b0, e_pn[4:0]});
    chk("R5 pix_n2", {6'b0, pix_n2}, {6'b0, e_pn[6:5]});
    chk("R5 mem_m", {1'b0, mem_m}, {1'b0, e_mm});
    chk("R5 mem_n1", {3'b0, mem_n1}, {3'b0, e_mn[4:0]});
    chk("R6 ctrl", pll_ctrl, e_ctrl);
    pll_read_sweep("R3 R4 R5 R7 written sweep");

    // R3 phase reset on index write
    do_wr(1, 8'h02); do_wr(3, 8'h11); do_wr(1, 8'h02); do_wr(3, 8'h22);
    e_pm = 7'h22;
    chk("R3 phase reset write", {1'b0, pix_m}, 8'h22);
    do_wr(2, 8'h02); do_rd(3, v); do_wr(2, 8'h02); do_rd(3, v);
    chk("R3 phase reset read", v, 8'h22);

    // R3 independent pointers
    do_wr(1, 8'h0A); do_wr(2, 8'h02);
    do_wr(3, 8'h3F); do_rd(3, v); chk("R3 interleave M", v, {1'b0, e_pm});
    do_wr(3, 8'h45); do_rd(3, v); chk("R3 interleave N", v, {1'b0, e_pn});
    chk("R3 mem_m", {1'b0, mem_m}, 8'h3F);
    chk("R3 mem_n2", {6'b0, mem_n2}, 8'h02);

    // R6 single-byte control slot
    do_wr(1, 8'h0E); do_wr(3, 8'h9C); do_wr(3, 8'h12);
    chk("R6 ctrl byte", pll_ctrl, 8'h9C);
    do_wr(2, 8'h0E); do_rd(3, v); chk("R6 ctrl read", v, 8'h9C);
    do_rd(3, v); chk("R7 slot 0F", v, 8'h00);
    do_rd(2, v); chk("R6 index after ctrl", v, 8'h0F);

    // R8 command exposure
    do_wr(1, 8'h00);
    for (int i = 0; i < 3; i++) begin do_rd(0, v); chk("R8 early read", v, 8'hFF); end
    do_rd(0, v); chk("R8 chip id", v, 8'h71);
    chk("R8 id nibble", {4'b0, v[7:4]}, 8'h07);
    do_rd(0, v); chk("R8 cmd read", v, 8'h00);
    do_wr(0, 8'h5A);
    chk("R8 cmd write", dac_cmd, 8'h5A);
    chk("R8 mask kept", pix_mask, 8'hFF);
    do_rd(0, v); chk("R8 cmd readback", v, 8'h5A);

    // R9 closing and broken runs
    do_rd(2, v);
    do_wr(0, 8'h3C);
    chk("R9 mask after close", pix_mask, 8'h3C);
    chk("R9 cmd kept", dac_cmd, 8'h5A);
    do_wr(1, 8'h00); do_rd(0, v); do_rd(0, v); do_rd(3, v);
    for (int i = 0; i < 4; i++) begin do_rd(0, v); chk("R9 broken by data", v, 8'h3C); end
    do_wr(1, 8'h00); for (int i = 0; i < 3; i++) do_rd(0, v);
    do_wr(0, 8'h3C); do_rd(0, v); chk("R9 broken by mask write", v, 8'h3C);
    do_wr(1, 8'h00); do_rd(0, v); do_rd(0, v);
    do_wr(1, 8'h00); for (int i = 0; i < 3; i++) do_rd(0, v);
    chk("R9 restart no id", v, 8'h3C);
    do_rd(0, v); chk("R9 restart id", v, 8'h71);

    // R11 hold between reads
    repeat (3) @(negedge clk);
    chk("R11 hold idle", bus_rdata, 8'h71);
    do_wr(2, 8'h00);
    chk("R11 hold over write", bus_rdata, 8'h71);

    // R2 palette and bank isolation
    pll_mode = 1'b0;
    do_wr(1, 8'h02); do_wr(3, 8'hEE); do_wr(3, 8'hDD);
    chk("R2 bank untouched", {1'b0, pix_m}, {1'b0, e_pm});
    do_wr(2, 8'h00); do_rd(3, v); chk("R2 palette kept", v, pal_exp[0]);
    do_rd(3, v); chk("R2 palette kept 1", v, pal_exp[1]);
    do_rd(3, v); chk("R2 palette new", v, 8'hEE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule